// File: doc/BRIEF.md
# Host Interrupt Status Doorbell Controller

This block builds the 32-bit read-only interrupt status word that a bus host sees for an attached I/O processor. Three conditions are reported: a sticky doorbell flag raised whenever the processor writes its system doorbell, a reply-available condition, and a pending flag for a host-to-processor doorbell that the processor has not yet serviced. Every other bit of the word reads as zero.

Reply-available is detected in one of two ways, chosen by a mode input. In standard mode it follows the reply FIFO's not-empty state. In alternate mode it is set whenever the host's consumer index differs from the reply write pointer. The host clears the doorbell flag by writing any value to the status address. A mask word gates the status bits onto a registered, active-low level interrupt.

Top module: `host_irq_status`

## Requirements
- R1: After reset the status word reads 0x0000_0000 and `irq_n` is 1.
- R2: Status bits 30..4 and 2..1 always read 0, whatever the inputs.
- R3: When `alt_mode` is 0, status bit 3 equals the inverse of `reply_empty`, in the same cycle.
- R4: When `alt_mode` is 1, status bit 3 is 1 exactly when `host_idx` differs from `reply_wptr`, in the same cycle, and `reply_empty` has no effect.
- R5: Status bit 31 follows `inb_pending`, in the same cycle.
- R6: A cycle with `proc_db_wr` high sets status bit 0 from the next cycle on. The bit stays at 1 until a host clear.
- R7: A cycle with `host_wr` high and `proc_db_wr` low clears bit 0 from the next cycle on. Bits 3 and 31 are not affected by host writes.
- R8: When `proc_db_wr` and `host_wr` are high in the same cycle, bit 0 is 1 in the next cycle.
- R9: `irq_n` is 0 one cycle after any status bit is 1 while its `irq_mask` bit is 0. It returns to 1 one cycle after no such bit remains. Masked bits never drive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_db_wr | input | 1 | Processor write strobe to the system doorbell |
| host_wr | input | 1 | Host write strobe to the status address (data ignored) |
| inb_pending | input | 1 | Host-to-processor doorbell not yet serviced by the processor |
| alt_mode | input | 1 | 0: FIFO-empty detection, 1: index-compare detection |
| reply_empty | input | 1 | Reply FIFO empty flag |
| host_idx | input | IDX_W | Host consumer index |
| reply_wptr | input | IDX_W | Reply write pointer |
| irq_mask | input | 32 | Per-bit interrupt mask, 1 = masked |
| status | output | 32 | Status word read by the host |
| irq_n | output | 1 | Registered active-low level interrupt |

## Verification
The assertions check on every cycle how the doorbell flag moves: set after a processor write, cleared after a lone host write, held otherwise. They also check that every edge of the interrupt output follows the unmasked status of the cycle before. Only the bench's scenarios can show that each reply-detection mode follows its chosen source and ignores the other, that the reserved bits stay zero under every input, and that a same-cycle set and clear resolves to set. The bench scenarios also cover masking of individual bits.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int STAT_W  = 32;
  localparam int DB_BIT  = 0;
  localparam int RPL_BIT = 3;
  localparam int INB_BIT = 31;
endpackage

// File: rtl/hist_db_flag.sv
module hist_db_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R6, R8: a set is never lost, even alongside a clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  // R7: a clear on its own drops the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
  // R6: sticky while neither strobe is active
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/hist_reply_detect.sv
module hist_reply_detect #(
  parameter int IDX_W = 16
) (
  input  logic             alt_mode,
  input  logic             reply_empty,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [IDX_W-1:0] reply_wptr,
  output logic             reply_pend
);
  logic fifo_view, idx_view;
  always_comb begin
    fifo_view  = ~reply_empty;
    idx_view   = (host_idx != reply_wptr);
    reply_pend = alt_mode ? idx_view : fifo_view;
  end
endmodule

// File: rtl/hist_irq_out.sv
module hist_irq_out #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_n
);
  logic live;
  always_comb live = |(stat_i & ~mask_i);

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~live;
  end

  // R9: the line only falls after an unmasked source was seen
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(live));
  // R9: the line only rises after every unmasked source was gone
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n) |-> !$past(live));
endmodule

// File: rtl/host_irq_status.sv
module host_irq_status
  import hist_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_db_wr,
  input  logic              host_wr,
  input  logic              inb_pending,
  input  logic              alt_mode,
  input  logic              reply_empty,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [IDX_W-1:0]  reply_wptr,
  input  logic [STAT_W-1:0] irq_mask,
  output logic [STAT_W-1:0] status,
  output logic              irq_n
);
  logic db_flag, reply_pend;

  hist_db_flag u_db (
    .clk(clk), .rst(rst), .set_i(proc_db_wr), .clr_i(host_wr), .flag_o(db_flag)
  );

  hist_reply_detect #(.IDX_W(IDX_W)) u_rpl (
    .alt_mode(alt_mode), .reply_empty(reply_empty),
    .host_idx(host_idx), .reply_wptr(reply_wptr), .reply_pend(reply_pend)
  );

  always_comb begin
    status          = '0;
    status[DB_BIT]  = db_flag;
    status[RPL_BIT] = reply_pend;
    status[INB_BIT] = inb_pending;
  end

  hist_irq_out #(.W(STAT_W)) u_irq (
    .clk(clk), .rst(rst), .stat_i(status), .mask_i(irq_mask), .irq_n(irq_n)
  );
endmodule

// File: tb/tb_host_irq_status.sv
module tb_host_irq_status;
  localparam int IW = 16;
  logic clk = 0, rst = 1;
  logic proc_db_wr = 0, host_wr = 0, inb_pending = 0, alt_mode = 0, reply_empty = 1;
  logic [IW-1:0] host_idx = '0, reply_wptr = '0;
  logic [31:0] irq_mask = '0;
  logic [31:0] status;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  host_irq_status #(.IDX_W(IW)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance one rising edge and settle
  task automatic step();
    @(posedge clk); #1;
  endtask
  // drive away from the edge
  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic t_reset();
    at_neg(); rst = 1; step(); step(); at_neg(); rst = 0; #1;
    chk("R1 status", status, 32'h0);
    chk("R1 irq_n", {31'b0, irq_n}, 32'h1);
  endtask

  task automatic t_reserved();
    at_neg(); irq_mask = '1; proc_db_wr = 1; inb_pending = 1; reply_empty = 0;
    step(); at_neg(); proc_db_wr = 0; #1;
    chk("R2 reserved zero all set", status & 32'h7FFF_FFF6, 32'h0);
    chk("R2 full word", status, 32'h8000_0009);
    at_neg(); host_wr = 1; step(); at_neg(); host_wr = 0; inb_pending = 0; reply_empty = 1; #1;
    chk("R2 reserved zero idle", status, 32'h0);
  endtask

  task automatic t_std_reply();
    at_neg(); alt_mode = 0; reply_empty = 0; host_idx = 5; reply_wptr = 5; #1;
    chk("R3 not empty", status, 32'h8);
    at_neg(); reply_empty = 1; host_idx = 1; reply_wptr = 7; #1;
    chk("R3 empty ignores index", status, 32'h0);
  endtask

  task automatic t_alt_reply();
    at_neg(); alt_mode = 1; reply_empty = 1; host_idx = 16'h1234; reply_wptr = 16'h1235; #1;
    chk("R4 differ", status, 32'h8);
    at_neg(); reply_empty = 0; host_idx = 16'hFFFF; reply_wptr = 16'hFFFF; #1;
    chk("R4 equal ignores empty", status, 32'h0);
    at_neg(); host_idx = 16'h8000; reply_wptr = 16'h0000; #1;
    chk("R4 msb differ", status, 32'h8);
    at_neg(); alt_mode = 0; reply_empty = 1; host_idx = 0; reply_wptr = 0; #1;
  endtask

  task automatic t_inbound();
    at_neg(); inb_pending = 1; #1;
    chk("R5 pending set", status, 32'h8000_0000);
    at_neg(); inb_pending = 0; #1;
    chk("R5 pending clear", status, 32'h0);
  endtask

  task automatic t_db_set_clear();
    at_neg(); proc_db_wr = 1; #1;
    chk("R6 not yet set", status, 32'h0);
    step(); at_neg(); proc_db_wr = 0; #1;
    chk("R6 set next cycle", status, 32'h1);
    step(); step();
    chk("R6 sticky", status, 32'h1);
    at_neg(); inb_pending = 1; reply_empty = 0; host_wr = 1; step(); at_neg(); host_wr = 0; #1;
    chk("R7 clear keeps bits 3 and 31", status, 32'h8000_0008);
    at_neg(); inb_pending = 0; reply_empty = 1; #1;
    chk("R7 cleared", status, 32'h0);
  endtask

  task automatic t_collision();
    at_neg(); proc_db_wr = 1; host_wr = 1; step(); at_neg(); proc_db_wr = 0; host_wr = 0; #1;
    chk("R8 set wins", status, 32'h1);
    at_neg(); host_wr = 1; step(); at_neg(); host_wr = 0; #1;
    chk("R8 cleanup", status, 32'h0);
  endtask

  task automatic t_irq();
    at_neg(); irq_mask = 32'h0; proc_db_wr = 1; step(); at_neg(); proc_db_wr = 0; #1;
    chk("R9 not yet low", {31'b0, irq_n}, 32'h1);
    step();
    chk("R9 low after unmasked", {31'b0, irq_n}, 32'h0);
    at_neg(); irq_mask = 32'h1; #1;
    chk("R9 still low before edge", {31'b0, irq_n}, 32'h0);
    step();
    chk("R9 masked releases", {31'b0, irq_n}, 32'h1);
    at_neg(); inb_pending = 1; irq_mask = 32'h8000_0001; step(); step();
    chk("R9 masked bit 31 no irq", {31'b0, irq_n}, 32'h1);
    at_neg(); irq_mask = 32'h0000_0001; step();
    chk("R9 bit 31 unmasked", {31'b0, irq_n}, 32'h0);
    at_neg(); inb_pending = 0; host_wr = 1; step(); at_neg(); host_wr = 0; step();
    chk("R9 released when gone", {31'b0, irq_n}, 32'h1);
    at_neg(); irq_mask = 32'h0; reply_empty = 0; step();
    chk("R9 reply drives irq", {31'b0, irq_n}, 32'h0);
    at_neg(); reply_empty = 1; step();
    chk("R9 reply gone", {31'b0, irq_n}, 32'h1);
  endtask

  initial begin
    t_reset();
    t_reserved();
    t_std_reply();
    t_alt_reply();
    t_inbound();
    t_db_set_clear();
    t_collision();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule